// File: doc/BRIEF.md
# Composite Video Level Encoder

This block is the digital front end of a 10-bit video DAC. On each rising clock edge it takes a pixel word and three video controls (sync, blank, bright). It maps the pixel word from one of four input formats to a plain intensity, where 0 is black and all ones is white. It then lays the video controls over that intensity in a fixed priority order. The result is an unsigned composite level code in DAC LSB units, meant to drive a current-steering array.

The output levels are fixed by parameters. Sync is code 0. The blanking pedestal is 409. Black sits a setup step of 77 above blanking, at 486. Full-scale data reaches white at 1509. The bright control lifts both black and white by 102, so enhanced white is 1611. Every control is registered together with the data, so each output code belongs to exactly one input sample, one clock later.

Top module: `compvid_enc`

## Requirements
- R1: The output code reflects the inputs captured at the previous rising clock edge: one cycle of latency. Inputs may change every cycle.
- R2: While the synchronous active-high reset is sampled high, the output becomes code 0 at that clock edge.
- R3: A captured sync of 1 gives output 0, whatever the blank, bright, format and data inputs are.
- R4: A captured sync of 0 with blank 1 gives output 409, whatever the bright, format and data inputs are.
- R5: With sync, blank and bright all 0, the output is 486 plus the normalized intensity N. It ranges from 486 (black) to 1509 (white).
- R6: With sync and blank 0 and bright 1, the output is 588 plus N. It ranges from 588 to 1611.
- R7: With binarySel=1 and invertSel=0, N equals the data word. Bit 9 is the MSB.
- R8: With binarySel=0 (two's complement), bit 9 of the data is flipped before any inversion. So 10'b1000000000 gives black and 10'b0111111111 gives white.
- R9: With invertSel=1, all ten bits are complemented after the format step. This swaps which codes give black and which give white.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pixData | input | 10 | Pixel word, bit 9 is MSB |
| binarySel | input | 1 | 1 = straight binary, 0 = two's complement |
| invertSel | input | 1 | 1 = reverse black/white mapping |
| syncIn | input | 1 | Sync control, highest priority |
| blankIn | input | 1 | Blank control |
| brightIn | input | 1 | Brightness boost control |
| levelOut | output | 12 | Composite level code in DAC LSB units |

## Verification
The hardest case to reach from the ports is a format or inversion change inside an unbroken stream, while the controls also toggle every cycle. A stale format decode or a control skewed by one cycle would only show up there. The stimulus therefore drives a new sample on every clock. It walks all 32 combinations of format, inverse and the three controls, each against a data list that includes the two's-complement black and white codes, and it checks each output against the sample driven one cycle earlier.

// File: rtl/compvid_pkg.sv
package compvid_pkg;
  typedef struct packed {
    logic forceSync;
    logic forceBlank;
    logic addBoost;
  } lvlCtrl_t;
endpackage

// File: rtl/compvid_ctrl.sv
module compvid_ctrl
  import compvid_pkg::*;
(
  input  logic     syncIn,
  input  logic     blankIn,
  input  logic     brightIn,
  output lvlCtrl_t ctrl
);
  // Priority: sync over blank over active video (bright only in active).
  always_comb begin
    ctrl.forceSync  = syncIn;
    ctrl.forceBlank = !syncIn && blankIn;
    ctrl.addBoost   = !syncIn && !blankIn && brightIn;
  end
endmodule

// File: rtl/compvid_dp.sv
module compvid_dp
  import compvid_pkg::*;
#(
  parameter int DATA_W     = 10,
  parameter int OUT_W      = 12,
  parameter int BLANK_LVL  = 409,
  parameter int SETUP_LVL  = 77,
  parameter int BOOST_LVL  = 102
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DATA_W-1:0] pixData,
  input  logic             binarySel,
  input  logic             invertSel,
  input  lvlCtrl_t         ctrl,
  output logic [OUT_W-1:0] levelOut
);
  localparam int MSB = DATA_W - 1;
  localparam logic [OUT_W-1:0] BLANK_CODE = OUT_W'(BLANK_LVL);
  localparam logic [OUT_W-1:0] BLACK_CODE = OUT_W'(BLANK_LVL + SETUP_LVL);
  localparam logic [OUT_W-1:0] BOOST_CODE = OUT_W'(BOOST_LVL);

  logic [DATA_W-1:0] normData;
  logic [OUT_W-1:0]  activeCode;
  logic [OUT_W-1:0]  nextLevel;

  // Per-bit normalization: MSB flip for two's complement, then inversion.
  for (genvar i = 0; i < DATA_W; i++) begin : g_norm
    if (i == MSB) begin : g_msb
      assign normData[i] = pixData[i] ^ !binarySel ^ invertSel;
    end else begin : g_low
      assign normData[i] = pixData[i] ^ invertSel;
    end
  end

  always_comb begin
    activeCode = BLACK_CODE + OUT_W'(normData);
    if (ctrl.addBoost) activeCode = activeCode + BOOST_CODE;
    if (ctrl.forceSync)       nextLevel = '0;
    else if (ctrl.forceBlank) nextLevel = BLANK_CODE;
    else                      nextLevel = activeCode;
  end

  always_ff @(posedge clk) begin
    if (rst) levelOut <= '0;
    else     levelOut <= nextLevel;
  end
endmodule

// File: rtl/compvid_enc.sv
module compvid_enc
  import compvid_pkg::*;
#(
  parameter int DATA_W    = 10,
  parameter int OUT_W     = 12,
  parameter int BLANK_LVL = 409,
  parameter int SETUP_LVL = 77,
  parameter int BOOST_LVL = 102
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DATA_W-1:0] pixData,
  input  logic             binarySel,
  input  logic             invertSel,
  input  logic             syncIn,
  input  logic             blankIn,
  input  logic             brightIn,
  output logic [OUT_W-1:0] levelOut
);
  lvlCtrl_t ctrl;

  compvid_ctrl u_ctrl (
    .syncIn  (syncIn),
    .blankIn (blankIn),
    .brightIn(brightIn),
    .ctrl    (ctrl)
  );

  compvid_dp #(
    .DATA_W   (DATA_W),
    .OUT_W    (OUT_W),
    .BLANK_LVL(BLANK_LVL),
    .SETUP_LVL(SETUP_LVL),
    .BOOST_LVL(BOOST_LVL)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .pixData  (pixData),
    .binarySel(binarySel),
    .invertSel(invertSel),
    .ctrl     (ctrl),
    .levelOut (levelOut)
  );
endmodule

// File: rtl/compvid_enc_chk.sv
module compvid_enc_chk #(
  parameter int DATA_W    = 10,
  parameter int OUT_W     = 12,
  parameter int BLANK_LVL = 409,
  parameter int SETUP_LVL = 77,
  parameter int BOOST_LVL = 102
) (
  input logic             clk,
  input logic             rst,
  input logic [DATA_W-1:0] pixData,
  input logic             binarySel,
  input logic             invertSel,
  input logic             syncIn,
  input logic             blankIn,
  input logic             brightIn,
  input logic [OUT_W-1:0] levelOut
);
  localparam int BLACK = BLANK_LVL + SETUP_LVL;
  localparam int WHITE = BLACK + (1 << DATA_W) - 1;

  logic pastRst = 1'b0;
  always_ff @(posedge clk) pastRst <= rst;

  // R2
  always_ff @(posedge clk) begin
    if (pastRst) begin
      reset_level_chk: assert (levelOut == '0);
    end
  end

  // R3
  sync_level_chk: assert property (@(posedge clk) disable iff (rst)
    syncIn |=> levelOut == '0);

  // R4
  blank_level_chk: assert property (@(posedge clk) disable iff (rst)
    (!syncIn && blankIn) |=> levelOut == OUT_W'(BLANK_LVL));

  // R5
  active_range_chk: assert property (@(posedge clk) disable iff (rst)
    (!syncIn && !blankIn && !brightIn) |=>
      (levelOut >= OUT_W'(BLACK) && levelOut <= OUT_W'(WHITE)));

  // R6
  boost_range_chk: assert property (@(posedge clk) disable iff (rst)
    (!syncIn && !blankIn && brightIn) |=>
      (levelOut >= OUT_W'(BLACK + BOOST_LVL) && levelOut <= OUT_W'(WHITE + BOOST_LVL)));

  // R7
  binary_black_chk: assert property (@(posedge clk) disable iff (rst)
    (!syncIn && !blankIn && !brightIn && binarySel && !invertSel && pixData == '0)
      |=> levelOut == OUT_W'(BLACK));

  // R9
  invert_black_chk: assert property (@(posedge clk) disable iff (rst)
    (!syncIn && !blankIn && !brightIn && binarySel && invertSel && pixData == '1)
      |=> levelOut == OUT_W'(BLACK));
endmodule

bind compvid_enc compvid_enc_chk #(
  .DATA_W(DATA_W), .OUT_W(OUT_W), .BLANK_LVL(BLANK_LVL),
  .SETUP_LVL(SETUP_LVL), .BOOST_LVL(BOOST_LVL)
) u_chk (.*);

// File: tb/sim_compvid_enc.sv
module sim_compvid_enc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  pixData = '0;
  logic        binarySel = 1'b1;
  logic        invertSel = 1'b0;
  logic        syncIn = 1'b0;
  logic        blankIn = 1'b0;
  logic        brightIn = 1'b0;
  logic [11:0] levelOut;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  compvid_enc u0 (.*);

  function automatic int expLevel(bit bin, bit inv, bit s, bit b, bit br, int d);
    int n;
    if (s) return 0;
    if (b) return 409;
    n = d;
    if (!bin) n = n ^ 512;
    if (inv) n = n ^ 1023;
    return 486 + (br ? 102 : 0) + n;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Previous sample, for the one-cycle-late comparison (R1)
  int  prevExp;
  string prevTag;
  bit  havePrev = 0;

  task automatic drive(bit bin, bit inv, bit s, bit b, bit br, int d);
    string tag;
    @(negedge clk);
    if (havePrev) check(prevTag, int'(levelOut), prevExp);
    binarySel = bin; invertSel = inv; syncIn = s; blankIn = b; brightIn = br;
    pixData = 10'(d);
    if (s) tag = "R3";
    else if (b) tag = "R4";
    else begin
      tag = br ? "R6 " : "R5 ";
      if (inv) tag = {tag, "R9"};
      else if (!bin) tag = {tag, "R8"};
      else tag = {tag, "R7"};
    end
    prevTag = {"R1 ", tag};
    prevExp = expLevel(bin, inv, s, b, br, d);
    havePrev = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R2 reset", int'(levelOut), 0);
    rst = 1'b0;
    // Stream: every cycle a new sample, checked one cycle later
    for (int c = 0; c < 32; c++) begin
      for (int k = 0; k < 20; k++) begin
        int d;
        case (k)
          0: d = 0;     1: d = 1;     2: d = 511;  3: d = 512;
          4: d = 513;   5: d = 1022;  6: d = 1023; 7: d = 341;
          default: d = (k * 97 + c * 13) % 1024;
        endcase
        drive(c[4], c[3], c[2], c[1], c[0], d);
      end
    end
    // Format flips on consecutive cycles (R8, R9 corner codes)
    drive(0, 0, 0, 0, 0, 512);
    drive(0, 0, 0, 0, 0, 511);
    drive(0, 1, 0, 0, 0, 512);
    drive(0, 1, 0, 0, 1, 511);
    drive(1, 1, 0, 0, 0, 0);
    @(negedge clk);
    check(prevTag, int'(levelOut), prevExp);
    havePrev = 0;
    // Reset in mid-stream with active video on the inputs (R2)
    syncIn = 0; blankIn = 0; pixData = 10'd700; rst = 1'b1;
    @(negedge clk);
    check("R2 midstream reset", int'(levelOut), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 R5 after reset", int'(levelOut), expLevel(binarySel, invertSel, 0, 0, brightIn, 700));
    done = 1;
  end

  initial begin
    for (int t = 0; t < 100000; t++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule